// File: doc/BRIEF.md
# Daisy-Chain Position Identifier

This block sits in every device on a shared serial bus whose devices are wired in a chain, each serial data output feeding the serial data input of the next device. After a bus reset, the controller holds its end of the chain low. That low level moves down the chain one serial clock per device. Each device times how long the low level takes to reach it, and that time is its position. The position becomes a 6-bit identifier, so later register accesses can be aimed at one device.

All inputs are sampled on the rising edge of the serial clock. A bus reset held high for at least two samples arms the block. The edge where the reset is first sampled low starts the count. The edge where the serial input is first sampled low ends it. The block then latches the count, raises a valid flag and drives its own serial output low for the next device.

The state machine has four states:
- IDLE: after power-on, or after a reset pulse that was too short.
- RST_HIGH: the bus reset is sampled high.
- COUNTING: armed and waiting for the serial input to go low.
- DONE: the identifier is latched or has overflowed.

Transitions:
- Any state → RST_HIGH on any high reset sample.
- RST_HIGH → IDLE on a low reset sample when the reset was not held long enough.
- RST_HIGH → DONE on a low reset sample with the serial input already low (identifier 0).
- RST_HIGH → COUNTING on a low reset sample with the serial input high.
- COUNTING → DONE when the serial input is sampled low, or on overflow.
- DONE holds until the next high reset sample.

Top module: `sid_chain_enum`

## Requirements
- R1: A bus reset sampled high on fewer than 2 consecutive edges does not arm the block. When such a pulse ends, the state returns to IDLE and `id_valid` stays 0 even if `sdi` is low.
- R2: On every edge where `bus_rst` is sampled 1, `sdo` becomes 1 and is visible from that edge onward. The edge after the reset is first sampled high therefore always sees `sdo` high.
- R3: The identifier equals the number of edges from the edge where `bus_rst` is sampled 0 (after arming) to the edge where `sdi` is sampled 0. It is 0 when both are sampled 0 on the same edge.
- R4: The identifier is 6 bits wide. Every value from 0 to 63 can be latched, including 63.
- R5: The edge that samples `sdi` low in the counting phase drives `sdo` to 0, so the next device samples the low level one edge later.
- R6: `id_valid` rises on the same edge that latches `dev_id`.
- R7: If `sdi` is still 1 on the edge where the count is already 63, the block enters DONE with `dev_id` = 63 and `id_valid` = 0, and `sdo` stays 1.
- R8: In DONE, `dev_id`, `id_valid` and `sdo` hold regardless of `sdi` until `bus_rst` is next sampled 1.
- R9: A high `bus_rst` sample clears `id_valid` and sets `dev_id` to 0.
- R10: While `por_n` is low, `sdo` is 1, `dev_id` is 0 and `id_valid` is 0.
- R11: In IDLE, a low `sdi` without a preceding armed reset has no effect: `id_valid` stays 0 and `sdo` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; every sample and update happens on its rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_rst | input | 1 | Bus reset line, sampled |
| sdi | input | 1 | Serial data input from the previous device in the chain |
| sdo | output | 1 | Serial data output to the next device in the chain |
| dev_id | output | 6 | Latched chain position identifier |
| id_valid | output | 1 | High once an identifier inside the legal range has been latched |

## Verification
A state machine stuck in COUNTING or dropped into IDLE shows at the ports within one edge of `sdi` falling. In that case `sdo` stays high and `id_valid` stays low where both should have changed. A count that is off by one appears directly as the wrong `dev_id` value on the edge `id_valid` rises. A faulty arming filter shows on the edge after a short reset pulse ends, as an unexpected valid flag. A faulty overflow branch shows on the edge where the count passes 63, as a wrong `dev_id` or `sdo` level.

// File: rtl/sid_pkg.sv
package sid_pkg;
    typedef enum logic [1:0] {
        SID_IDLE     = 2'd0,
        SID_RST_HIGH = 2'd1,
        SID_COUNTING = 2'd2,
        SID_DONE     = 2'd3
    } sid_state_e;
endpackage

// File: rtl/sid_rst_filter.sv
module sid_rst_filter #(
    parameter int MIN_RST_HI = 2
) (
    input  logic sclk,
    input  logic por_n,
    input  logic bus_rst,
    output logic armed
);
    localparam int HW = $clog2(MIN_RST_HI + 1);

    logic [HW-1:0] hi_cnt;

    // consecutive high samples, saturating at the arming threshold
    always_ff @(posedge sclk or negedge por_n) begin
        if (!por_n) begin
            hi_cnt <= '0;
        end else if (!bus_rst) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HW'(MIN_RST_HI)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign armed = (hi_cnt == HW'(MIN_RST_HI));
endmodule

// File: rtl/sid_pos_counter.sv
module sid_pos_counter #(
    parameter int ID_W = 6
) (
    input  logic            sclk,
    input  logic            por_n,
    input  logic            load_one,
    input  logic            step,
    output logic [ID_W-1:0] cnt,
    output logic            at_max
);
    localparam logic [ID_W-1:0] ONE = ID_W'(1);

    always_ff @(posedge sclk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (load_one) begin
            cnt <= ONE;
        end else if (step && !at_max) begin
            cnt <= cnt + ONE;
        end
    end

    assign at_max = (cnt == '1);
endmodule

// File: rtl/sid_chain_enum.sv
module sid_chain_enum
    import sid_pkg::*;
#(
    parameter int ID_W       = 6,
    parameter int MIN_RST_HI = 2
) (
    input  logic            sclk,
    input  logic            por_n,
    input  logic            bus_rst,
    input  logic            sdi,
    output logic            sdo,
    output logic [ID_W-1:0] dev_id,
    output logic            id_valid
);
    sid_state_e      state, state_n;
    logic            armed;
    logic            cnt_load, cnt_step, at_max;
    logic [ID_W-1:0] cnt;
    logic            sdo_n, val_n;
    logic [ID_W-1:0] id_n;

    sid_rst_filter #(.MIN_RST_HI(MIN_RST_HI)) u_filt (
        .sclk    (sclk),
        .por_n   (por_n),
        .bus_rst (bus_rst),
        .armed   (armed)
    );

    sid_pos_counter #(.ID_W(ID_W)) u_cnt (
        .sclk     (sclk),
        .por_n    (por_n),
        .load_one (cnt_load),
        .step     (cnt_step),
        .cnt      (cnt),
        .at_max   (at_max)
    );

    // next state and next output values
    always_comb begin
        state_n  = state;
        sdo_n    = sdo;
        id_n     = dev_id;
        val_n    = id_valid;
        cnt_load = 1'b0;
        cnt_step = 1'b0;
        if (bus_rst) begin
            state_n = SID_RST_HIGH;
            sdo_n   = 1'b1;
            id_n    = '0;
            val_n   = 1'b0;
        end else begin
            unique case (state)
                SID_IDLE: begin
                    state_n = SID_IDLE;
                end
                SID_RST_HIGH: begin
                    if (!armed) begin
                        state_n = SID_IDLE;
                    end else if (!sdi) begin
                        state_n = SID_DONE;
                        sdo_n   = 1'b0;
                        id_n    = '0;
                        val_n   = 1'b1;
                    end else begin
                        state_n  = SID_COUNTING;
                        cnt_load = 1'b1;
                    end
                end
                SID_COUNTING: begin
                    if (!sdi) begin
                        state_n = SID_DONE;
                        sdo_n   = 1'b0;
                        id_n    = cnt;
                        val_n   = 1'b1;
                    end else if (at_max) begin
                        state_n = SID_DONE;
                        id_n    = cnt;
                        val_n   = 1'b0;
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
                SID_DONE: begin
                    state_n = SID_DONE;
                end
                default: begin
                    state_n = SID_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge sclk or negedge por_n) begin
        if (!por_n) begin
            state <= SID_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // output registers
    always_ff @(posedge sclk or negedge por_n) begin
        if (!por_n) begin
            sdo      <= 1'b1;
            dev_id   <= '0;
            id_valid <= 1'b0;
        end else begin
            sdo      <= sdo_n;
            dev_id   <= id_n;
            id_valid <= val_n;
        end
    end
endmodule

// File: rtl/sid_chain_enum_chk.sv
module sid_chain_enum_chk
    import sid_pkg::*;
#(
    parameter int ID_W       = 6,
    parameter int MIN_RST_HI = 2
) (
    input logic            sclk,
    input logic            por_n,
    input logic            bus_rst,
    input logic            sdi,
    input logic            sdo,
    input logic [ID_W-1:0] dev_id,
    input logic            id_valid,
    input sid_state_e      state
);
    logic [7:0] hi_run;

    always_ff @(posedge sclk or negedge por_n) begin
        if (!por_n) begin
            hi_run <= '0;
        end else if (!bus_rst) begin
            hi_run <= '0;
        end else if (hi_run != 8'hFF) begin
            hi_run <= hi_run + 8'd1;
        end
    end

    // R1: a short reset pulse never yields a valid identifier
    a_r1_short_pulse: assert property (@(posedge sclk) disable iff (!por_n)
        (!bus_rst && hi_run != 8'd0 && int'(hi_run) < MIN_RST_HI) |=> !id_valid);

    // R2: a high reset sample drives the chain output high
    a_r2_sdo_high: assert property (@(posedge sclk) disable iff (!por_n)
        bus_rst |=> sdo);

    // R5: the edge that sees sdi low while counting drives sdo low
    a_r5_pass_zero: assert property (@(posedge sclk) disable iff (!por_n)
        (!bus_rst && state == SID_COUNTING && !sdi) |=> (!sdo && id_valid));

    // R7: overflow leaves the top code, invalid, sdo high
    a_r7_no_overflow: assert property (@(posedge sclk) disable iff (!por_n)
        (state == SID_DONE && !id_valid) |-> (dev_id == '1 && sdo));

    // R8: a latched identifier holds until the next reset sample
    a_r8_hold: assert property (@(posedge sclk) disable iff (!por_n)
        (id_valid && !bus_rst) |=> (id_valid && $stable(dev_id) && !sdo));

    // R9: a reset sample clears the identifier
    a_r9_clear: assert property (@(posedge sclk) disable iff (!por_n)
        bus_rst |=> (!id_valid && dev_id == '0));
endmodule

bind sid_chain_enum sid_chain_enum_chk #(
    .ID_W       (ID_W),
    .MIN_RST_HI (MIN_RST_HI)
) u_chk (
    .sclk     (sclk),
    .por_n    (por_n),
    .bus_rst  (bus_rst),
    .sdi      (sdi),
    .sdo      (sdo),
    .dev_id   (dev_id),
    .id_valid (id_valid),
    .state    (state)
);

// File: tb/tb_sid_chain_enum.sv
module tb_sid_chain_enum;
    localparam int PERIOD = 10;

    logic       sclk = 1'b0;
    logic       por_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       sdi = 1'b1;
    logic       sdo;
    logic [5:0] dev_id;
    logic       id_valid;

    int total = 0;
    int bad   = 0;

    sid_chain_enum dut (
        .sclk     (sclk),
        .por_n    (por_n),
        .bus_rst  (bus_rst),
        .sdi      (sdi),
        .sdo      (sdo),
        .dev_id   (dev_id),
        .id_valid (id_valid)
    );

    always #(PERIOD/2) sclk = ~sclk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive inputs, let one rising edge sample them, then settle past it
    task automatic tick(input logic r, input logic d);
        bus_rst = r;
        sdi     = d;
        @(posedge sclk);
        #1;
    endtask

    task automatic arm(input int n_hi);
        for (int i = 0; i < n_hi; i++) begin
            tick(1'b1, 1'b1);
            check("R2 sdo high after reset sample", int'(sdo), 1);
            check("R9 valid cleared by reset", int'(id_valid), 0);
        end
    endtask

    // device at position k; k > 63 exercises overflow
    task automatic t_position(input int k);
        arm(3);
        for (int j = 0; j < 64; j++) begin
            tick(1'b0, (j >= k) ? 1'b0 : 1'b1);
            if (j < k && j < 63) begin
                check("R3 not yet valid", int'(id_valid), 0);
                check("R3 sdo still high", int'(sdo), 1);
            end else if (j == k) begin
                check("R3 R4 identifier value", int'(dev_id), k);
                check("R6 valid with latch", int'(id_valid), 1);
                check("R5 sdo low after sdi low", int'(sdo), 0);
                break;
            end else begin
                check("R7 overflow id", int'(dev_id), 63);
                check("R7 overflow invalid", int'(id_valid), 0);
                check("R7 overflow sdo", int'(sdo), 1);
                break;
            end
        end
    endtask

    task automatic t_hold();
        int saved;
        saved = int'(dev_id);
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, i[0]);
            check("R8 id held", int'(dev_id), saved);
            check("R8 valid held", int'(id_valid), 1);
            check("R8 sdo held low", int'(sdo), 0);
        end
    endtask

    task automatic t_short_pulse();
        tick(1'b1, 1'b1);
        check("R2 sdo high", int'(sdo), 1);
        check("R9 id cleared", int'(dev_id), 0);
        tick(1'b0, 1'b0);
        check("R1 short pulse no valid", int'(id_valid), 0);
        tick(1'b0, 1'b0);
        check("R1 short pulse still no valid", int'(id_valid), 0);
        check("R1 sdo stays high", int'(sdo), 1);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            tick(1'b0, 1'b0);
            check("R11 idle ignores sdi valid", int'(id_valid), 0);
            check("R11 idle ignores sdi sdo", int'(sdo), 1);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 2 + 3);
        check("R10 reset sdo", int'(sdo), 1);
        check("R10 reset id", int'(dev_id), 0);
        check("R10 reset valid", int'(id_valid), 0);
        por_n = 1'b1;
        @(posedge sclk);
        #1;
        t_idle();
        t_position(0);
        t_hold();
        t_position(1);
        t_position(5);
        t_hold();
        t_position(37);
        t_position(63);
        t_hold();
        t_short_pulse();
        t_position(70);
        tick(1'b0, 1'b0);
        check("R7 overflow ignores late sdi", int'(id_valid), 0);
        t_position(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule